// File: doc/BRIEF.md
# Word-Parallel Iterative Feistel Cipher Core

This block encrypts or decrypts one N-bit text under an N-bit key. It runs one Feistel round per clock cycle and updates the key state in the same cycle, so no round keys are stored. Both halves of the text and of the key are arrays of B-bit words. Words are added modulo 2^B with no carry between words. A 3-bit substitution acts across each triple of words, one bit slice at a time. Word and bit rotations are plain wiring.

A one-cycle `start_i` pulse loads the text, the key and the direction. The core then runs NR rounds. In the round at the midpoint, the two key halves are exchanged. From that round on, the schedule retraces its earlier states in reverse. The sequence of round keys is therefore a palindrome, and decryption reuses the same schedule with the inverse round. When the core finishes, it latches `result_o` and pulses `done_o` for one cycle. Encryption and decryption share one substitution/add path; a multiplexer chooses which text half feeds it.

Top module: `lwc_feistel_core`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is all zeros.
- R2: A `start_i` seen while idle is accepted. `done_o` is high for exactly one cycle, NR clock edges after the accepting edge.
- R3: Encryption follows these definitions.
  - Layout: the left half is bits [N-1:N/2]. Word j of a half is bits [jB+B-1:jB].
  - Round t uses key K_t. K_t is the lower key half for t ≤ floor(NR/2) and the upper half after that.
  - Each round maps (L,R) to (R, Wrot(L) xor G(R,K_t)). G(x,k) = bitrot(S(x ⊞ k)), where ⊞ is a word-wise addition modulo 2^B.
  - Wrot moves word j to word j+1, with the top word wrapping to word 0.
  - The result has its halves exchanged: the final R becomes the upper half.
- R4: S maps 0..7 to 0,5,6,7,4,3,1,2. For word triple 3g, 3g+1, 3g+2, bit p of word 3g is input bit 0 and bit p of word 3g+2 is input bit 2. Outputs go back the same way. bitrot rotates word 3g right by one bit, leaves word 3g+1 alone and rotates word 3g+2 left by one bit.
- R5: With `decrypt_i`=1:
  - The loaded halves are exchanged, so the upper half of the text becomes R.
  - Each round maps (L,R) to (Wrot⁻¹(R xor G(L,K_t)), L).
  - The result is not exchanged.
  - Decrypting an encrypted text under the same key returns the plaintext.
- R6: A `start_i` pulse while the core is busy is ignored. The running operation finishes with its own result and timing.
- R7: `result_o` changes only in the cycle `done_o` is high, and it holds between completions.
- R8: The key state (KL,KR) steps to (KR, KL xor Wrot(bitrot(S(KR ⊞ C)))).
  - C is zero except for the low words, which hold the round constant split into B-bit words, with no carry between words.
  - The constant is t+1 for t < floor(NR/2), and NR-1-t from the midpoint on.
  - At t = floor(NR/2) the key halves are exchanged before the step.
- R9: NR defaults to 3N/4 + 2(N/(2B) + floor(B/2)), rounded up to the next odd number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request; accepted only while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled with start |
| text_i | input | N | Plaintext or ciphertext, sampled with start |
| key_i | input | N | Key, sampled with start |
| result_o | output | N | Latest result, held until the next completion |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The assertions assume a legal parameter set, which the elaboration checks enforce: N a multiple of 6B, NR odd, and the constant fitting in the key half. They also assume that text, key and direction matter only at the accepting edge. The stimulus drives `start_i` as single-cycle pulses and changes the data inputs only in cycles where the core ignores them. One run deliberately pulses start mid-operation with altered text and direction, to show that busy-time requests are dropped. Two instances are exercised: one in which the round constant fits in one word, and one in which it spans two words.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

   // 3-bit substitution: 0..7 -> 0,5,6,7,4,3,1,2
   function automatic logic [2:0] sub3(input logic [2:0] x);
      logic [2:0] y;
      case (x)
         3'd0:    y = 3'd0;
         3'd1:    y = 3'd5;
         3'd2:    y = 3'd6;
         3'd3:    y = 3'd7;
         3'd4:    y = 3'd4;
         3'd5:    y = 3'd3;
         3'd6:    y = 3'd1;
         default: y = 3'd2;
      endcase
      return y;
   endfunction

   // default round count, forced odd
   function automatic int nr_default(input int n, input int b);
      int r;
      r = (3 * n) / 4 + 2 * (n / (2 * b) + b / 2);
      return r | 1;
   endfunction

endpackage

// File: rtl/lwc_mix.sv
// Word-wise add, sliced substitution across word triples, triple bit rotation.
module lwc_mix #(
   parameter int B         = 8,
   parameter int NB        = 6,
   parameter int ADD_WORDS = NB
) (
   input  logic [B*NB-1:0]        x_i,
   input  logic [B*ADD_WORDS-1:0] y_i,
   output logic [B*NB-1:0]        z_o
);
   localparam int H  = B * NB;
   localparam int NG = NB / 3;

   if (NB % 3 != 0) begin : g_err_nb
      $error("lwc_mix: word count must be a multiple of 3");
   end
   if (ADD_WORDS < 1 || ADD_WORDS > NB) begin : g_err_add
      $error("lwc_mix: adder count out of range");
   end
   if (B < 2) begin : g_err_b
      $error("lwc_mix: word size below 2");
   end

   logic [H-1:0] sum;
   logic [H-1:0] sb;

   for (genvar j = 0; j < NB; j++) begin : g_add
      if (j < ADD_WORDS) begin : g_on
         assign sum[j*B +: B] = x_i[j*B +: B] + y_i[j*B +: B];
      end else begin : g_off
         assign sum[j*B +: B] = x_i[j*B +: B];
      end
   end

   for (genvar g = 0; g < NG; g++) begin : g_grp
      localparam int W0 = 3 * g * B;
      localparam int W1 = W0 + B;
      localparam int W2 = W0 + 2 * B;
      for (genvar p = 0; p < B; p++) begin : g_bit
         logic [2:0] tin;
         assign tin = {sum[W2+p], sum[W1+p], sum[W0+p]};
         assign {sb[W2+p], sb[W1+p], sb[W0+p]} = lwc_pkg::sub3(tin);
      end
      assign z_o[W0 +: B] = {sb[W0], sb[W0+1 +: B-1]};
      assign z_o[W1 +: B] = sb[W1 +: B];
      assign z_o[W2 +: B] = {sb[W2 +: B-1], sb[W2+B-1]};
   end

endmodule

// File: rtl/lwc_seq.sv
// Round counter, round constant and completion pulse.
module lwc_seq #(
   parameter int NR    = 93,
   parameter int CBITS = 6,
   parameter int CNTW  = $clog2(NR)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             load_o,
   output logic             busy_o,
   output logic             mid_o,
   output logic             last_o,
   output logic             done_o,
   output logic [CNTW-1:0]  cnt_o,
   output logic [CBITS-1:0] rc_o
);
   localparam int MID = NR / 2;
   localparam logic [CNTW-1:0] MIDC  = CNTW'(MID);
   localparam logic [CNTW-1:0] LASTC = CNTW'(NR - 1);

   logic            busy_q, done_q;
   logic [CNTW-1:0] cnt_q;

   assign load_o = start_i & ~busy_q;
   assign mid_o  = busy_q & (cnt_q == MIDC);
   assign last_o = busy_q & (cnt_q == LASTC);
   assign busy_o = busy_q;
   assign done_o = done_q;
   assign cnt_o  = cnt_q;

   always_comb begin
      if (cnt_q < MIDC) rc_o = CBITS'(cnt_q + CNTW'(1));
      else              rc_o = CBITS'(LASTC - cnt_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= last_o;
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LASTC) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + CNTW'(1);
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);                                              // R2
   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> !busy_q);                                              // R2
   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (cnt_q <= LASTC));                                     // R2
   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && start_i && cnt_q != LASTC) |=>
         (busy_q && cnt_q == $past(cnt_q) + CNTW'(1)));                 // R6

endmodule

// File: rtl/lwc_feistel_core.sv
module lwc_feistel_core #(
   parameter int N  = 96,
   parameter int B  = 8,
   parameter int NR = lwc_pkg::nr_default(N, B)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic         decrypt_i,
   input  logic [N-1:0] text_i,
   input  logic [N-1:0] key_i,
   output logic [N-1:0] result_o,
   output logic         done_o
);
   localparam int H      = N / 2;
   localparam int NB     = H / B;
   localparam int MID    = NR / 2;
   localparam int CNTW   = $clog2(NR);
   localparam int CBITS  = $clog2(MID + 1);
   localparam int CWORDS = (CBITS + B - 1) / B;
   localparam int CVW    = CWORDS * B;

   if (N % (6 * B) != 0) begin : g_err_n
      $error("lwc_feistel_core: N must be a multiple of 6*B");
   end
   if (NR % 2 == 0 || NR < 3) begin : g_err_nr
      $error("lwc_feistel_core: NR must be odd and at least 3");
   end
   if (CWORDS > NB) begin : g_err_c
      $error("lwc_feistel_core: round constant wider than a key half");
   end

   logic            load, busy, mid, last;
   logic [CNTW-1:0] cnt;
   logic [CBITS-1:0] rc;

   lwc_seq #(.NR(NR), .CBITS(CBITS), .CNTW(CNTW)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .load_o (load),
      .busy_o (busy),
      .mid_o  (mid),
      .last_o (last),
      .done_o (done_o),
      .cnt_o  (cnt),
      .rc_o   (rc)
   );

   logic [N-1:0] st_q, ks_q, res_q;
   logic         dec_q;

   // data round
   logic [H-1:0] s_l, s_r, rk, fin, g_out, l_rot, x_inv;
   logic [N-1:0] st_nx;

   assign s_l   = st_q[N-1:H];
   assign s_r   = st_q[H-1:0];
   assign rk    = (cnt <= CNTW'(MID)) ? ks_q[H-1:0] : ks_q[N-1:H];
   assign fin   = dec_q ? s_l : s_r;
   assign l_rot = {s_l[H-B-1:0], s_l[H-1:H-B]};
   assign x_inv = s_r ^ g_out;

   lwc_mix #(.B(B), .NB(NB), .ADD_WORDS(NB)) u_mix_d (
      .x_i(fin), .y_i(rk), .z_o(g_out)
   );

   assign st_nx = dec_q ? {x_inv[B-1:0], x_inv[H-1:B], s_l}
                        : {s_r, l_rot ^ g_out};

   // key round
   logic [N-1:0]   kin, ks_nx;
   logic [H-1:0]   k_mix, k_rot;
   logic [CVW-1:0] cvec;

   assign kin   = mid ? {ks_q[H-1:0], ks_q[N-1:H]} : ks_q;
   assign cvec  = CVW'(rc);
   assign k_rot = {k_mix[H-B-1:0], k_mix[H-1:H-B]};

   lwc_mix #(.B(B), .NB(NB), .ADD_WORDS(CWORDS)) u_mix_k (
      .x_i(kin[H-1:0]), .y_i(cvec), .z_o(k_mix)
   );

   assign ks_nx = {kin[H-1:0], kin[N-1:H] ^ k_rot};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= '0;
         ks_q  <= '0;
         res_q <= '0;
         dec_q <= 1'b0;
      end else if (load) begin
         st_q  <= decrypt_i ? {text_i[H-1:0], text_i[N-1:H]} : text_i;
         ks_q  <= key_i;
         dec_q <= decrypt_i;
      end else if (busy) begin
         st_q <= st_nx;
         ks_q <= ks_nx;
         if (last) res_q <= dec_q ? st_nx : {st_nx[H-1:0], st_nx[N-1:H]};
      end
   end

   assign result_o = res_q;

   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));                                   // R7
   AST_LOAD_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy) |=> (busy && !done_o));                        // R2

endmodule

// File: tb/tb_lwc_feistel_core.sv
module tb_lwc_feistel_core;
   typedef int wa_t [8];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        s_b = 1'b0, d_b = 1'b0, dn_b;
   logic [95:0] t_b = '0, k_b = '0, r_b;
   logic        s_s = 1'b0, d_s = 1'b0, dn_s;
   logic [47:0] t_s = '0, k_s = '0, r_s;

   lwc_feistel_core dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_b), .decrypt_i(d_b),
      .text_i(t_b), .key_i(k_b), .result_o(r_b), .done_o(dn_b));

   lwc_feistel_core #(.N(48), .B(4)) dut_s (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_s), .decrypt_i(d_s),
      .text_i(t_s), .key_i(k_s), .result_o(r_s), .done_o(dn_s));

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [191:0] VEC [6] = '{
      {96'h000000000000000000000000, 96'h000000000000000000000000},
      {96'hffffffffffffffffffffffff, 96'hffffffffffffffffffffffff},
      {96'h0123456789abcdef01234567, 96'h89abcdef0123456789abcdef},
      {96'h800000000000000000000001, 96'h000000000000000000000000},
      {96'h000000000000000000000000, 96'h00000000000000000000000f},
      {96'hdeadbeefcafef00d13572468, 96'h55aa55aa55aa55aa33cc33cc}
   };

   function automatic int nr_of(int n, int b);
      int r;
      r = 3 * n / 4 + 2 * (n / (2 * b) + b / 2);
      if (r % 2 == 0) r = r + 1;
      return r;
   endfunction

   function automatic wa_t unpk(logic [47:0] x, int nb, int b);
      wa_t w;
      for (int j = 0; j < 8; j++) w[j] = 0;
      for (int j = 0; j < nb; j++) w[j] = int'((x >> (j * b)) & ((48'd1 << b) - 48'd1));
      return w;
   endfunction

   function automatic logic [47:0] pk(wa_t w, int nb, int b);
      logic [47:0] r = '0;
      for (int j = 0; j < nb; j++) r = r | (48'(w[j]) << (j * b));
      return r;
   endfunction

   function automatic wa_t mixm(wa_t x, wa_t y, int nb, int b);
      int sbt [8] = '{0, 5, 6, 7, 4, 3, 1, 2};
      int mask = (1 << b) - 1;
      wa_t a, s, z;
      for (int j = 0; j < 8; j++) begin a[j] = 0; s[j] = 0; z[j] = 0; end
      for (int j = 0; j < nb; j++) a[j] = (x[j] + y[j]) & mask;
      for (int g = 0; g < nb / 3; g++)
         for (int p = 0; p < b; p++) begin
            int idx, o;
            idx = ((a[3*g] >> p) & 1) | (((a[3*g+1] >> p) & 1) << 1) | (((a[3*g+2] >> p) & 1) << 2);
            o = sbt[idx];
            s[3*g]   = s[3*g]   | ((o & 1) << p);
            s[3*g+1] = s[3*g+1] | (((o >> 1) & 1) << p);
            s[3*g+2] = s[3*g+2] | (((o >> 2) & 1) << p);
         end
      for (int g = 0; g < nb / 3; g++) begin
         z[3*g]   = ((s[3*g] >> 1) | (s[3*g] << (b - 1))) & mask;
         z[3*g+1] = s[3*g+1];
         z[3*g+2] = ((s[3*g+2] << 1) | (s[3*g+2] >> (b - 1))) & mask;
      end
      return z;
   endfunction

   function automatic wa_t wrotm(wa_t x, int nb);
      wa_t z;
      for (int j = 0; j < 8; j++) z[j] = 0;
      for (int j = 0; j < nb; j++) z[(j + 1) % nb] = x[j];
      return z;
   endfunction

   function automatic wa_t winvm(wa_t x, int nb);
      wa_t z;
      for (int j = 0; j < 8; j++) z[j] = 0;
      for (int j = 0; j < nb; j++) z[j] = x[(j + 1) % nb];
      return z;
   endfunction

   function automatic wa_t xorm(wa_t x, wa_t y);
      wa_t z;
      for (int j = 0; j < 8; j++) z[j] = x[j] ^ y[j];
      return z;
   endfunction

   // behavioural model built from R3, R4, R5, R8, R9
   function automatic logic [95:0] cipher(int n, int b, logic [95:0] txt, logic [95:0] kk, bit dec);
      int hw = n / 2;
      int nb = hw / b;
      int nr = nr_of(n, b);
      int m = nr / 2;
      int mask = (1 << b) - 1;
      logic [95:0] hm = (96'd1 << hw) - 96'd1;
      wa_t l, r, kl, kr, rk, g, nl, nr_w, cw, km, tmp;
      logic [95:0] res;
      if (dec) begin
         l = unpk(48'(txt & hm), nb, b);
         r = unpk(48'((txt >> hw) & hm), nb, b);
      end else begin
         l = unpk(48'((txt >> hw) & hm), nb, b);
         r = unpk(48'(txt & hm), nb, b);
      end
      kl = unpk(48'((kk >> hw) & hm), nb, b);
      kr = unpk(48'(kk & hm), nb, b);
      for (int t = 0; t < nr; t++) begin
         int c;
         rk = (t <= m) ? kr : kl;
         if (!dec) begin
            g = mixm(r, rk, nb, b);
            nl = r;
            nr_w = xorm(wrotm(l, nb), g);
         end else begin
            g = mixm(l, rk, nb, b);
            nr_w = l;
            nl = winvm(xorm(r, g), nb);
         end
         if (t == m) begin tmp = kl; kl = kr; kr = tmp; end
         c = (t < m) ? t + 1 : nr - 1 - t;
         for (int j = 0; j < 8; j++) cw[j] = (j * b < 31) ? ((c >> (j * b)) & mask) : 0;
         km = mixm(kr, cw, nb, b);
         tmp = kr;
         kr = xorm(kl, wrotm(km, nb));
         kl = tmp;
         l = nl;
         r = nr_w;
      end
      if (dec) res = (96'(pk(l, nb, b)) << hw) | 96'(pk(r, nb, b));
      else     res = (96'(pk(r, nb, b)) << hw) | 96'(pk(l, nb, b));
      return res;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [95:0] act, logic [95:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic op_b(input logic [95:0] tx, input logic [95:0] kx, input bit dec, input bit poke,
                       output logic [95:0] res, output int lat);
      @(negedge clk);
      t_b = tx; k_b = kx; d_b = dec; s_b = 1'b1;
      @(negedge clk);
      s_b = 1'b0;
      lat = 0;
      while (!dn_b && lat < 400) begin
         if (poke && lat == 10) begin t_b = ~tx; d_b = ~dec; s_b = 1'b1; end
         else s_b = 1'b0;
         @(negedge clk);
         lat++;
      end
      s_b = 1'b0;
      res = r_b;
      @(negedge clk);
      chk(dn_b == 1'b0, "R2", "done width", 96'(dn_b), 96'd0);
      chk(r_b == res, "R7", "result held", r_b, res);
   endtask

   task automatic op_s(input logic [47:0] tx, input logic [47:0] kx, input bit dec,
                       output logic [47:0] res, output int lat);
      @(negedge clk);
      t_s = tx; k_s = kx; d_s = dec; s_s = 1'b1;
      @(negedge clk);
      s_s = 1'b0;
      lat = 0;
      while (!dn_s && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      res = r_s;
      @(negedge clk);
      chk(dn_s == 1'b0, "R2", "small done width", 96'(dn_s), 96'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [95:0] pt, kk, exp, res, res2;
      logic [47:0] pts, kks, rs, rs2;
      int lat;
      int nrb = nr_of(96, 8);
      int nrs = nr_of(48, 4);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dn_b == 1'b0, "R1", "done after reset", 96'(dn_b), 96'd0);
      chk(r_b == '0, "R1", "result after reset", r_b, 96'd0);
      chk(dn_s == 1'b0, "R1", "small done after reset", 96'(dn_s), 96'd0);
      chk(r_s == '0, "R1", "small result after reset", 96'(r_s), 96'd0);

      for (int i = 0; i < 6; i++) begin
         pt = VEC[i][191:96];
         kk = VEC[i][95:0];
         exp = cipher(96, 8, pt, kk, 1'b0);
         op_b(pt, kk, 1'b0, 1'b0, res, lat);
         chk(res == exp, "R3", "encrypt vs model (R4 S-box, R8 schedule)", res, exp);
         chk(lat == nrb, "R9", "round count latency (R2)", 96'(lat), 96'(nrb));
         op_b(res, kk, 1'b1, 1'b0, res2, lat);
         chk(res2 == pt, "R5", "decrypt round trip", res2, pt);
         exp = cipher(96, 8, pt, kk, 1'b1);
         op_b(pt, kk, 1'b1, 1'b0, res2, lat);
         chk(res2 == exp, "R5", "decrypt vs model", res2, exp);

         pts = pt[47:0];
         kks = kk[47:0];
         exp = cipher(48, 4, 96'(pts), 96'(kks), 1'b0);
         op_s(pts, kks, 1'b0, rs, lat);
         chk(96'(rs) == exp, "R8", "two-word constant instance vs model", 96'(rs), exp);
         chk(lat == nrs, "R9", "small round count", 96'(lat), 96'(nrs));
         op_s(rs, kks, 1'b1, rs2, lat);
         chk(rs2 == pts, "R5", "small round trip", 96'(rs2), 96'(pts));
      end

      // R6: start pulse with altered text and mode while busy
      pt = VEC[5][191:96];
      kk = VEC[5][95:0];
      exp = cipher(96, 8, pt, kk, 1'b0);
      op_b(pt, kk, 1'b0, 1'b1, res, lat);
      chk(res == exp, "R6", "busy start ignored result", res, exp);
      chk(lat == nrb, "R6", "busy start ignored timing", 96'(lat), 96'(nrb));

      // R7: result stays put while idle with inputs moving
      t_b = ~t_b; k_b = ~k_b;
      repeat (5) @(negedge clk);
      chk(r_b == res, "R7", "idle hold", r_b, res);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule